// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block keeps the modem status byte of a PC-style serial port. Four external handshake inputs (carrier detect, ring indicator, data set ready, clear to send) are brought into the clock domain through a synchronizer. They are compared against the last sampled levels, and any change is latched into sticky change bits. Software reads the status byte through a read strobe. In normal operation a read clears the sticky change bits. A delta-pending flag tells the interrupt encoder that at least one change bit is set.

When loopback is enabled by bit 4 of the 5-bit modem control input, the read value is built from the modem control outputs in a fixed mapping instead of from the external inputs. In this mode reads do not clear the change bits, and external changes keep being latched in the background.

Top module: `mdm_status_top`

## Requirements
- R1: After reset the status read value is 8'hB0 (carrier detect, data set ready and clear to send high, ring low, no change bits) and deltaPending is 0.
- R2: Outside loopback the read value is {dcd, ri, dsr, cts, dDcd, riTrail, dDsr, dCts}, with bit 7 = carrier detect and bit 0 = clear-to-send change.
- R3: A rising or falling change on carrier detect, data set ready or clear to send sets its change bit (bit 3, 1 or 0 respectively).
- R4: The ring change bit (bit 2) sets only when ring goes from 1 to 0; a 0 to 1 transition leaves it clear.
- R5: A read strobe outside loopback clears bits 3:0 at the clock edge that ends the strobe cycle and leaves bits 7:4 unchanged. A change latched at that same edge still sets its bit.
- R6: With modemCtl[4]=1 the read value is {modemCtl[3], modemCtl[2], modemCtl[0], modemCtl[1], 4'b0000}.
- R7: In loopback a read strobe does not clear the stored change bits. External changes during loopback are still latched and appear once loopback is left.
- R8: deltaPending is the OR of the four stored change bits, in both modes.
- R9: An input change appears in the read value exactly SYNC_STAGES+1 clock edges after it is applied: after 3 edges with the default of 2, and not after 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modemCtl | input | 5 | Modem control: bit 4 loopback, bits 3:0 control outputs |
| dcdIn | input | 1 | External carrier detect, asynchronous |
| riIn | input | 1 | External ring indicator, asynchronous |
| dsrIn | input | 1 | External data set ready, asynchronous |
| ctsIn | input | 1 | External clear to send, asynchronous |
| rdStrobe | input | 1 | One-cycle read strobe of the status byte |
| statusRd | output | 8 | Status read value |
| deltaPending | output | 1 | Any stored change bit set |

## Verification
The assertions assume that external inputs hold at least long enough to pass the synchronizer. They also assume that modemCtl changes only between clock edges, so each sampled level is a clean one. The stimulus drives every input on the falling clock edge and holds each input pattern for several cycles before the next read. The sweep covers all 256 ordered pairs of old and new input patterns. It also covers all 32 modem control values, including a read placed on the very edge where a change is latched.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LINES = 4;
  // level nibble positions inside the status byte upper half and change nibble
  localparam int DCD_IDX = 3;
  localparam int RI_IDX  = 2;
  localparam int DSR_IDX = 1;
  localparam int CTS_IDX = 0;
  localparam logic [LINES-1:0] LVL_RESET = 4'b1011;

  typedef struct packed {
    logic             loopSel;
    logic             clrDelta;
    logic [LINES-1:0] setDelta;
  } mdmStrobes_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= {STAGES{RST_VAL[b]}};
      else       chainQ <= {chainQ[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chainQ[STAGES-1];
  end
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic             loopEn,
  input  logic             rdStrobe,
  input  logic [LINES-1:0] syncLvl,
  input  logic [LINES-1:0] levelQ,
  output mdmStrobes_t      strobes
);
  logic [LINES-1:0] setVec;

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (i == RI_IDX) begin : g_trail
      assign setVec[i] = levelQ[i] & ~syncLvl[i];
    end else begin : g_any
      assign setVec[i] = levelQ[i] ^ syncLvl[i];
    end
  end

  always_comb begin
    strobes.loopSel  = loopEn;
    strobes.clrDelta = rdStrobe & ~loopEn;
    strobes.setDelta = setVec;
  end
endmodule

// File: rtl/mdm_dp.sv
module mdm_dp
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mdmStrobes_t      strobes,
  input  logic [LINES-1:0] syncLvl,
  input  logic [3:0]       ctlOut,
  input  logic             rdStrobe,
  output logic [LINES-1:0] levelQ,
  output logic [7:0]       statusRd,
  output logic             deltaPending
);
  logic [LINES-1:0] deltaQ;
  logic [7:0]       loopVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= LVL_RESET;
      deltaQ <= '0;
    end else begin
      levelQ <= syncLvl;
      deltaQ <= (strobes.clrDelta ? '0 : deltaQ) | strobes.setDelta;
    end
  end

  assign loopVal      = {ctlOut[3], ctlOut[2], ctlOut[0], ctlOut[1], 4'b0000};
  assign statusRd     = strobes.loopSel ? loopVal : {levelQ, deltaQ};
  assign deltaPending = |deltaQ;

  // R3
  dcd_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ[DCD_IDX] != $past(levelQ[DCD_IDX])) |-> deltaQ[DCD_IDX]);

  // R4
  ri_trail_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deltaQ[RI_IDX]) |-> ($past(levelQ[RI_IDX]) && !levelQ[RI_IDX]));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrDelta && strobes.setDelta == '0) |=> deltaQ == '0);

  // R6
  loop_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loopSel |-> statusRd[3:0] == 4'b0000);

  // R7
  loop_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && strobes.loopSel && deltaQ != '0) |=> deltaQ != '0);
endmodule

// File: rtl/mdm_status_top.sv
module mdm_status_top
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] modemCtl,
  input  logic       dcdIn,
  input  logic       riIn,
  input  logic       dsrIn,
  input  logic       ctsIn,
  input  logic       rdStrobe,
  output logic [7:0] statusRd,
  output logic       deltaPending
);
  logic [LINES-1:0] rawLvl;
  logic [LINES-1:0] syncLvl;
  logic [LINES-1:0] levelQ;
  mdmStrobes_t      strobes;

  assign rawLvl = {dcdIn, riIn, dsrIn, ctsIn};

  mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RESET)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(rawLvl), .syncOut(syncLvl));

  mdm_ctrl ctrl_i (
    .loopEn(modemCtl[4]), .rdStrobe(rdStrobe), .syncLvl(syncLvl),
    .levelQ(levelQ), .strobes(strobes));

  mdm_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .syncLvl(syncLvl),
    .ctlOut(modemCtl[3:0]), .rdStrobe(rdStrobe), .levelQ(levelQ),
    .statusRd(statusRd), .deltaPending(deltaPending));

  // R8
  pending_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deltaPending && !modemCtl[4]) |-> statusRd[3:0] != 4'b0000);
endmodule

// File: tb/mdm_status_top_tb.sv
module mdm_status_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] modemCtl = 5'b0;
  logic       dcdIn = 1'b1, riIn = 1'b0, dsrIn = 1'b1, ctsIn = 1'b1;
  logic       rdStrobe = 1'b0;
  logic [7:0] statusRd;
  logic       deltaPending;
  int         nChecks = 0;
  int         nFails = 0;

  mdm_status_top dut_i (
    .clk(clk), .rstN(rstN), .modemCtl(modemCtl), .dcdIn(dcdIn), .riIn(riIn),
    .dsrIn(dsrIn), .ctsIn(ctsIn), .rdStrobe(rdStrobe),
    .statusRd(statusRd), .deltaPending(deltaPending));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setIn(input logic [3:0] v);
    {dcdIn, riIn, dsrIn, ctsIn} = v;
  endtask

  function automatic logic [3:0] expDelta(input logic [3:0] f, input logic [3:0] t);
    return ((f ^ t) & 4'b1011) | ((f & ~t) & 4'b0100);
  endfunction

  function automatic logic [7:0] loopExp(input logic [4:0] m);
    return {m[3], m[2], m[0], m[1], 4'b0000};
  endfunction

  task automatic doRead();
    rdStrobe = 1'b1;
    tick();
    rdStrobe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", statusRd, 8'hB0);
    check("R1 reset pending", {7'b0, deltaPending}, 8'h00);
    rstN = 1'b1;
    tick();
    check("R1 after release", statusRd, 8'hB0);
    check("R1 after release pending", {7'b0, deltaPending}, 8'h00);

    // R2 R3 R4 R9: every ordered pair of input patterns
    for (int f = 0; f < 16; f++) begin
      for (int t = 0; t < 16; t++) begin
        logic [3:0] fv, tv, ed;
        fv = f[3:0];
        tv = t[3:0];
        ed = expDelta(fv, tv);
        setIn(fv);
        repeat (4) tick();
        doRead();
        setIn(tv);
        repeat (2) tick();
        check("R9 not yet visible", statusRd, {fv, 4'b0000});
        tick();
        check("R2 R3 R4 level and change", statusRd, {tv, ed});
        check("R8 pending", {7'b0, deltaPending}, {7'b0, |ed});
        doRead();
        check("R5 cleared by read", statusRd, {tv, 4'b0000});
      end
    end

    // R5: change latched on the same edge as the read wins
    setIn(4'b1111);
    repeat (4) tick();
    doRead();
    setIn(4'b0111);
    repeat (2) tick();
    doRead();
    check("R5 set wins over clear", statusRd, 8'h78);

    // R6: every control value in loopback, and normal mode readback
    doRead();
    for (int m = 0; m < 32; m++) begin
      logic [4:0] mv;
      mv = m[4:0];
      modemCtl = mv;
      #1;
      if (mv[4]) check("R6 loopback map", statusRd, loopExp(mv));
      else       check("R6 normal when off", statusRd, 8'h70);
      tick();
    end

    // R7 R8: loopback read keeps changes; background latching
    modemCtl = 5'b0;
    setIn(4'b1011);
    repeat (4) tick();
    doRead();
    check("R7 clean start", statusRd, 8'hB0);
    setIn(4'b1010);
    repeat (3) tick();
    modemCtl = 5'b10101;
    #1;
    check("R8 pending in loopback", {7'b0, deltaPending}, 8'h01);
    check("R6 loopback value", statusRd, loopExp(5'b10101));
    doRead();
    setIn(4'b0010);
    repeat (3) tick();
    modemCtl = 5'b00000;
    #1;
    check("R7 kept through loopback read", statusRd, 8'h29);
    doRead();
    check("R7 normal read clears", statusRd, 8'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule